// File: doc/BRIEF.md
# Serial ADC Command and Result Port

This block is the device side of the serial port of a multichannel 14-bit sampling converter. A host lowers an active-low chip select, toggles a serial clock and presents command bits on a data input. The block takes in an 8-bit command word, MSB first, and picks the channel from its leading bits. It then raises an acquire phase, fires a single convert strobe at a fixed serial-clock edge and shifts the conversion result back out, MSB first. The analog front end is not part of this block. The converted value arrives on a parallel input and is captured at the convert strobe.

A width-select input, latched when chip select falls, picks a narrow framing or a wide framing. In the narrow framing the sample falls on the 6th falling edge and the result begins on the 8th falling edge, so a frame is 24 serial clocks long. In the wide framing acquisition lasts eight clocks longer: the sample falls on the 14th falling edge and the result begins on the 16th. The serial pins are oversampled by the block clock through a synchronizer. Every event is keyed to a count of serial-clock edges since chip select fell. If chip select rises while the block is acquiring or converting, the frame is aborted and the block enters shutdown. A later falling edge of chip select brings it out of shutdown.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, dout_oe and dout are 0, status is idle (0), chan_sel is 0, cfg is 0 and conv_strobe is 0.
- R2: When chip select falls, dout_oe becomes 1, dout is 0 and status is idle (0), whatever state the block was in before.
- R3: The 1st to 3rd data-input bits, each latched on a rising serial edge, form chan_sel, with the 1st bit as its MSB. chan_sel updates on the 3rd rising edge and keeps its old value before that edge. Status becomes acquire (1) at the 3rd rising edge.
- R4: The 4th to 8th data-input bits form cfg, with the 4th bit as its MSB. cfg updates on the 8th rising edge and keeps its old value before that edge.
- R5: With wide_mode=0, conv_strobe fires on the 6th falling serial edge and status becomes convert (2) at that edge.
- R6: With wide_mode=1, conv_strobe fires on the 14th falling serial edge and status becomes convert (2) at that edge.
- R7: The result MSB appears on dout at the 8th falling edge (wide_mode=0) or at the 16th (wide_mode=1). The remaining result bits follow on successive falling edges, and then two zero bits. Status returns to idle (0) at the first result edge. dout is 0 before that edge.
- R8: Falling serial edges after the 16 read bits, with chip select still low, drive 0 on dout.
- R9: A rise of chip select while status is acquire or convert puts status into shutdown (3) and stops any later strobe. A rise in any other state leaves status idle. dout_oe is 0 after every rise of chip select.
- R10: A falling edge of chip select takes the block out of shutdown and restarts edge counting, so the next frame completes normally.
- R11: conv_data is captured at the convert strobe. Changes to it after the strobe do not alter the shifted result.
- R12: conv_strobe is a single-cycle pulse, and at most one pulse occurs per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| wide_mode | input | 1 | 1 selects wide framing, 0 selects narrow; latched when chip select falls |
| conv_data | input | 14 | Parallel conversion value, captured at the convert strobe |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for dout; 0 means high impedance |
| chan_sel | output | 3 | Selected channel |
| cfg | output | 5 | Configuration bits from the command word |
| conv_strobe | output | 1 | One-cycle sample/convert pulse |
| status | output | 2 | 0 idle, 1 acquire, 2 convert, 3 shutdown |

## Verification
The hardest situation to reach from the ports is the shutdown entered by raising chip select in the middle of a frame. It must happen once after the 3rd rising edge and before the strobe, and once after the strobe but before the first result edge. The bench stops its serial clock after a chosen edge count in each framing, raises chip select there, and then runs a full frame to show that shutdown is left cleanly. The bench also changes conv_data right after the strobe edge in every frame, so a result that follows the live input instead of the captured value shows up in the read-back word.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2,
        ST_SHDN = 2'd3
    } port_state_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
        logic din;
    } port_evt_t;

    function automatic int unsigned pick_edge(logic wide, int unsigned narrow_at,
                                              int unsigned wide_at);
        return wide ? wide_at : narrow_at;
    endfunction

endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync
    import adc_port_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      sclk,
    input  logic      din,
    output port_evt_t evt
);
    logic [STAGES-1:0] cs_pipe, sck_pipe, din_pipe;
    logic              cs_prev, sck_prev;
    logic              cs_q, sck_q;

    assign cs_q  = cs_pipe[STAGES-1];
    assign sck_q = sck_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_pipe  <= '1;
            sck_pipe <= '0;
            din_pipe <= '0;
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_pipe[0]  <= cs_n;
            sck_pipe[0] <= sclk;
            din_pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                cs_pipe[i]  <= cs_pipe[i-1];
                sck_pipe[i] <= sck_pipe[i-1];
                din_pipe[i] <= din_pipe[i-1];
            end
            cs_prev  <= cs_q;
            sck_prev <= sck_q;
        end
    end

    always_comb begin
        evt.cs_fall  = cs_prev & ~cs_q;
        evt.cs_rise  = ~cs_prev & cs_q;
        evt.sck_rise = ~cs_q & ~cs_prev & ~sck_prev & sck_q;
        evt.sck_fall = ~cs_q & ~cs_prev & sck_prev & ~sck_q;
        evt.din      = din_pipe[STAGES-1];
    end
endmodule

// File: rtl/adc_cmd_shift.sv
module adc_cmd_shift #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] cmd_next
);
    logic [W-1:0] cmd_q;

    assign cmd_next = {cmd_q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cmd_q <= '0;
        end else if (shift) begin
            cmd_q <= cmd_next;
        end
    end
endmodule

// File: rtl/adc_res_shift.sv
module adc_res_shift #(
    parameter int RES_W = 14,
    parameter int RD_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic             shift,
    input  logic [RES_W-1:0] data,
    output logic             msb
);
    localparam int PAD = RD_W - RES_W;

    logic [RD_W-1:0] sreg;

    assign msb = sreg[RD_W-1];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= RD_W'(data) << PAD;
        end else if (shift) begin
            sreg <= {sreg[RD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int CMD_W         = 8,
    parameter int CHAN_W        = 3,
    parameter int RES_W         = 14,
    parameter int RD_W          = 16,
    parameter int SEL_EDGE      = 3,
    parameter int NARROW_SAMPLE = 6,
    parameter int WIDE_EXTRA    = 8,
    parameter int CNT_W         = 6,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    din,
    input  logic                    wide_mode,
    input  logic [RES_W-1:0]        conv_data,
    output logic                    dout,
    output logic                    dout_oe,
    output logic [CHAN_W-1:0]       chan_sel,
    output logic [CMD_W-CHAN_W-1:0] cfg,
    output logic                    conv_strobe,
    output logic [1:0]              status
);
    localparam int CFG_W       = CMD_W - CHAN_W;
    localparam int SAMPLE_WIDE = NARROW_SAMPLE + WIDE_EXTRA;
    localparam int RESULT_N    = CMD_W;
    localparam int RESULT_WIDE = 2 * CMD_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    port_evt_t          evt;
    port_state_e        state_q;
    logic [CNT_W-1:0]   rise_cnt, fall_cnt, rise_nxt, fall_nxt;
    logic [CNT_W-1:0]   sample_at, result_at;
    logic               wide_q;
    logic [RES_W-1:0]   data_q;
    logic [CFG_W-1:0]   cmd_next;
    logic               cmd_shift, res_load, res_shift, res_clear, res_msb;

    adc_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .din (din), .evt (evt)
    );

    assign rise_nxt  = rise_cnt + CNT_W'(rise_cnt != CNT_MAX);
    assign fall_nxt  = fall_cnt + CNT_W'(fall_cnt != CNT_MAX);
    assign sample_at = CNT_W'(pick_edge(wide_q, NARROW_SAMPLE, SAMPLE_WIDE));
    assign result_at = CNT_W'(pick_edge(wide_q, RESULT_N, RESULT_WIDE));

    assign cmd_shift = evt.sck_rise && (rise_cnt < CNT_W'(CMD_W));
    assign res_load  = evt.sck_fall && (fall_nxt == result_at) && (state_q == ST_CONV);
    assign res_shift = evt.sck_fall && (fall_nxt > result_at);
    assign res_clear = evt.cs_fall | evt.cs_rise;

    adc_cmd_shift #(.W(CFG_W)) u_cmd (
        .clk (clk), .rst (rst), .clear (evt.cs_fall), .shift (cmd_shift),
        .din (evt.din), .cmd_next (cmd_next)
    );

    adc_res_shift #(.RES_W(RES_W), .RD_W(RD_W)) u_res (
        .clk (clk), .rst (rst), .clear (res_clear), .load (res_load),
        .shift (res_shift), .data (data_q), .msb (res_msb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            dout_oe     <= 1'b0;
            chan_sel    <= '0;
            cfg         <= '0;
            conv_strobe <= 1'b0;
            rise_cnt    <= '0;
            fall_cnt    <= '0;
            wide_q      <= 1'b0;
            data_q      <= '0;
        end else begin
            conv_strobe <= 1'b0;
            if (evt.cs_fall) begin
                state_q  <= ST_IDLE;
                dout_oe  <= 1'b1;
                rise_cnt <= '0;
                fall_cnt <= '0;
                wide_q   <= wide_mode;
            end else if (evt.cs_rise) begin
                dout_oe <= 1'b0;
                if (state_q == ST_ACQ || state_q == ST_CONV) begin
                    state_q <= ST_SHDN;
                end
            end else if (evt.sck_rise) begin
                rise_cnt <= rise_nxt;
                if (rise_nxt == CNT_W'(SEL_EDGE)) begin
                    chan_sel <= cmd_next[CHAN_W-1:0];
                    if (state_q == ST_IDLE) state_q <= ST_ACQ;
                end
                if (rise_nxt == CNT_W'(CMD_W)) begin
                    cfg <= cmd_next;
                end
            end else if (evt.sck_fall) begin
                fall_cnt <= fall_nxt;
                if (fall_nxt == sample_at && state_q == ST_ACQ) begin
                    state_q     <= ST_CONV;
                    conv_strobe <= 1'b1;
                    data_q      <= conv_data;
                end else if (fall_nxt == result_at && state_q == ST_CONV) begin
                    state_q <= ST_IDLE;
                end
            end
        end
    end

    assign dout   = dout_oe & res_msb;
    assign status = state_q;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk
    import adc_port_pkg::*;
#(
    parameter int CHAN_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        status,
    input logic              conv_strobe,
    input logic              dout,
    input logic              dout_oe,
    input logic [CHAN_W-1:0] chan_sel
);
    AST_STROBE_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        conv_strobe |-> status == ST_CONV) else $error("strobe outside convert"); // R5

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_strobe |=> !conv_strobe) else $error("strobe wider than one cycle"); // R12

    AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        status == ST_SHDN |-> (!dout_oe && !conv_strobe)) else $error("shutdown not quiet"); // R9

    AST_DOUT_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> !dout) else $error("dout active while disabled"); // R1

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
        (status == ST_CONV && $past(status) == ST_CONV) |-> $stable(chan_sel))
        else $error("channel moved during convert"); // R3

    AST_SHDN_EXIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(status) == ST_SHDN && status != ST_SHDN) |-> status == ST_IDLE)
        else $error("shutdown left to wrong state"); // R10
endmodule

bind adc_serial_port adc_serial_port_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk (clk), .rst (rst), .status (status), .conv_strobe (conv_strobe),
    .dout (dout), .dout_oe (dout_oe), .chan_sel (chan_sel)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
    localparam int W = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, wide_mode = 1'b0;
    logic [13:0] conv_data = '0;
    logic dout, dout_oe, conv_strobe;
    logic [2:0] chan_sel;
    logic [4:0] cfg;
    logic [1:0] status;

    adc_serial_port dut (
        .clk (clk), .rst (rst), .cs_n (cs_n), .sclk (sclk), .din (din),
        .wide_mode (wide_mode), .conv_data (conv_data), .dout (dout),
        .dout_oe (dout_oe), .chan_sel (chan_sel), .cfg (cfg),
        .conv_strobe (conv_strobe), .status (status)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int strobe_cnt = 0, strobe_at = 0, cur_fall = 0;
    bit done = 1'b0;
    logic rd [0:40];
    logic [1:0] st_f [0:40], st_r [0:40];
    logic [2:0] chan_r [0:40];
    logic [4:0] cfg_r [0:40];
    logic oe_cs, dout_cs, oe_end;
    logic [1:0] st_cs, st_end;
    logic [2:0] prev_chan = '0;
    logic [4:0] prev_cfg = '0;

    // {wide, cmd, data}
    localparam logic [22:0] VEC [6] = '{
        {1'b0, 8'b101_10011, 14'h2A5B},
        {1'b1, 8'b011_01100, 14'h1C3E},
        {1'b0, 8'b111_11111, 14'h3FFF},
        {1'b1, 8'b000_00001, 14'h0001},
        {1'b0, 8'b010_10101, 14'h2000},
        {1'b1, 8'b110_00110, 14'h0F0F}
    };

    always @(posedge clk) begin
        if (!rst && conv_strobe) begin
            strobe_cnt <= strobe_cnt + 1;
            strobe_at  <= cur_fall;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic waitw();
        repeat (W) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] cmd, input logic wide,
                         input logic [13:0] data, input int ncyc);
        strobe_cnt = 0; strobe_at = 0; cur_fall = 0;
        conv_data = data; wide_mode = wide;
        @(negedge clk) cs_n = 1'b0;
        waitw();
        oe_cs = dout_oe; dout_cs = dout; st_cs = status;
        for (int k = 1; k <= ncyc; k++) begin
            din = (k <= 8) ? cmd[8-k] : 1'b0;
            @(negedge clk) sclk = 1'b1;
            waitw();
            chan_r[k] = chan_sel; cfg_r[k] = cfg; st_r[k] = status;
            @(negedge clk) begin sclk = 1'b0; cur_fall = k; end
            waitw();
            rd[k] = dout; st_f[k] = status;
            if (k == (wide ? 14 : 6)) conv_data = ~data;
        end
        @(negedge clk) cs_n = 1'b1;
        waitw();
        st_end = status; oe_end = dout_oe;
    endtask

    task automatic check_full(input logic [7:0] cmd, input logic wide, input logic [13:0] data);
        int s;
        logic [15:0] word;
        s = wide ? 16 : 8;
        check("R2 oe at cs fall", int'(oe_cs), 1);
        check("R2 dout at cs fall", int'(dout_cs), 0);
        check("R2 status at cs fall", int'(st_cs), 0);
        check("R3 chan before 3rd rise", int'(chan_r[2]), int'(prev_chan));
        check("R3 chan at 3rd rise", int'(chan_r[3]), int'(cmd[7:5]));
        check("R3 acquire at 3rd rise", int'(st_r[3]), 1);
        check("R4 cfg before 8th rise", int'(cfg_r[7]), int'(prev_cfg));
        check("R4 cfg at 8th rise", int'(cfg_r[8]), int'(cmd[4:0]));
        if (wide) check("R6 strobe edge wide", strobe_at, 14);
        else      check("R5 strobe edge narrow", strobe_at, 6);
        check("R12 one strobe", strobe_cnt, 1);
        check("R7 convert before result", int'(st_f[s-1]), 2);
        check("R7 dout zero before result", int'(rd[s-1]), 0);
        check("R7 idle at result start", int'(st_f[s]), 0);
        for (int j = 0; j < 16; j++) word[15-j] = rd[s+j];
        check("R7 R11 result word", int'(word), int'({data, 2'b00}));
        check("R8 extra edge zero a", int'(rd[s+16]), 0);
        check("R8 extra edge zero b", int'(rd[s+17]), 0);
        check("R9 idle after normal end", int'(st_end), 0);
        check("R9 oe off after cs rise", int'(oe_end), 0);
        prev_chan = cmd[7:5];
        prev_cfg = cmd[4:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        waitw();
        check("R1 reset oe", int'(dout_oe), 0);
        check("R1 reset dout", int'(dout), 0);
        check("R1 reset status", int'(status), 0);
        check("R1 reset chan", int'(chan_sel), 0);
        check("R1 reset cfg", int'(cfg), 0);
        check("R1 reset strobe", int'(conv_strobe), 0);

        for (int i = 0; i < 6; i++) begin
            logic w;
            w = VEC[i][22];
            frame(VEC[i][21:14], w, VEC[i][13:0], (w ? 16 : 8) + 17);
            check_full(VEC[i][21:14], w, VEC[i][13:0]);
        end

        // abort during convert, narrow framing
        frame(8'b100_01010, 1'b0, 14'h1234, 7);
        check("R9 convert before abort", int'(st_f[7]), 2);
        check("R9 shutdown after convert abort", int'(st_end), 3);
        check("R9 oe off in shutdown", int'(oe_end), 0);
        repeat (20) @(negedge clk);
        check("R9 shutdown held", int'(status), 3);
        prev_chan = 3'b100;
        prev_cfg = cfg;

        // recovery from shutdown with a full frame
        frame(8'b001_11000, 1'b0, 14'h0A5A, 25);
        check("R10 idle after cs fall from shutdown", int'(st_cs), 0);
        check_full(8'b001_11000, 1'b0, 14'h0A5A);

        // abort during acquire, wide framing
        frame(8'b011_00011, 1'b1, 14'h3333, 10);
        check("R9 acquire before abort", int'(st_f[10]), 1);
        check("R9 shutdown after acquire abort", int'(st_end), 3);
        check("R9 R12 no strobe in aborted acquire", strobe_cnt, 0);

        // chip select rise before acquisition starts
        frame(8'b111_00000, 1'b0, 14'h0001, 2);
        check("R10 leave shutdown", int'(st_cs), 0);
        check("R9 early rise stays idle", int'(st_end), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule